// File: doc/BRIEF.md
# Cascadable Prioritized Interrupt Controller

This block collects interrupt requests from two banks of sources and presents them to a processor as two active-low request lines: a normal request (`irq_n`) and a fast request (`fiq_n`). Each bank serves a fixed number of sources, 32 by default. Every source has its own configuration word that sets a priority, picks edge or level capture, and, in the first bank only, sends the source to the fast request. Sources are qualified by a pending register and a mask register. A priority arbiter then picks one winner per request type.

A winner is latched into a readable number register, and its request line is held asserted. Both stay frozen until software writes the matching acknowledge bit. The second bank does not drive the processor directly. Its held normal request is merged into one chosen source of the first bank, the cascade input. When the first bank reports that source, software reads the second bank's number register and adds the bank size to get the global number. Software then acknowledges the second bank and after it the first.

All registers sit behind a simple valid/ready register bus. Address bit 8 selects the bank and the low eight bits are a byte offset inside that bank's 256-byte window.

Top module: `irqc_cascade`

## Requirements
- R1: Address bit 8 selects the bank (0 first, 1 second) and bits 7:0 are the byte offset. Offsets: 0x00 pending, 0x04 mask, 0x08 normal winner number, 0x0C fast winner number, 0x10 acknowledge control, and 0x80+4*i the configuration word of source i. A second-bank source j has global number 32+j.
- R2: The configuration word stores bit 0 (route to fast), bit 1 (1 = level capture, 0 = edge capture) and bits 6:2 (priority). A read returns those 7 bits with all upper bits zero. Every word resets to 0.
- R3: Fast routing takes effect only in the first bank. In the second bank the routing bit is ignored, and the source always competes for the normal request.
- R4: A mask bit of 1 blocks its source and a mask bit of 0 enables it. Both mask registers reset to all ones. A source is active when it is pending and unmasked.
- R5: Pending reads 0 after reset. A write to pending clears every edge-captured bit whose written data bit is 0. Level-captured bits are unaffected by such a write.
- R6: An edge-captured source sets its pending bit on a rising input and keeps it until cleared. A level-captured pending bit equals the input as sampled at the previous clock edge.
- R7: The normal (0x08) and fast (0x0C) number registers read the latched winner index, or 0 when nothing is latched.
- R8: Writing 1 to control bit 0 releases the normal request, and writing 1 to bit 1 releases the fast request. Writing 0x3 releases both. The matching line deasserts right after the write's clock edge.
- R9: Among active candidates of one request type, the lowest priority value wins. On equal priority, the lower source index wins.
- R10: Once a request is latched, its number and line stay unchanged until the matching acknowledge, whatever the sources do.
- R11: After an acknowledge, arbitration runs again at the next clock edge. A still-active source reasserts the line one cycle after the release.
- R12: First-bank source CASC_IDX (default 0) sees the OR of its external input and the second bank's held normal request. Clearing the chain needs an acknowledge to both banks.
- R13: `bus_ready` is high for exactly the cycle after each valid cycle, and read data is presented with it. A write takes effect at the clock edge where valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Bank select (bit 8) and byte offset |
| bus_wdata | input | 32 | Write data |
| bus_ready | output | 1 | Access completed, one cycle after valid |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| prim_src | input | N_SRC | First-bank interrupt inputs |
| sec_src | input | N_SRC | Second-bank interrupt inputs |
| irq_n | output | 1 | Normal request, active low |
| fiq_n | output | 1 | Fast request, active low |

## Verification
The bench builds the default configuration: 32 sources per bank and the cascade on first-bank source 0. This small setup allows a sweep over every single-source pattern, followed by mixed, partly masked patterns. In these patterns the priorities are chosen so that ties occur, and the winner is computed arithmetically in the bench. With the cascade on source 0, the bench also walks the full two-bank chain, including an acknowledge given in the wrong order. The same setup covers the one-cycle re-arbitration timing after a release and the edge versus level pending behaviour.

// File: rtl/irqc_pkg.sv
// Shared constants and types for the interrupt controller banks.
// Assumes a 256-byte register window per bank with word-aligned offsets.
package irqc_pkg;
    localparam int PRIO_W = 5;
    localparam int CFG_W  = PRIO_W + 2;

    localparam logic [7:0] OFS_PEND  = 8'h00;
    localparam logic [7:0] OFS_MASK  = 8'h04;
    localparam logic [7:0] OFS_NUM_N = 8'h08;
    localparam logic [7:0] OFS_NUM_F = 8'h0C;
    localparam logic [7:0] OFS_CTRL  = 8'h10;

    // Per-source configuration word, bit 0 at the bottom.
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              lvl_mode;
        logic              to_fast;
    } src_cfg_t;
endpackage

// File: rtl/irqc_capture.sv
// Pending capture for one bank: edge sources latch rising inputs until cleared,
// level sources track the sampled input. Assumes inputs are already synchronous.
module irqc_capture #(
    parameter int N_SRC = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src,
    input  logic [N_SRC-1:0] lvl_mode,
    input  logic             clr_we,
    input  logic [N_SRC-1:0] keep,
    output logic [N_SRC-1:0] pend
);
    logic [N_SRC-1:0] src_q;

    // Previous input sample for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) src_q <= '0;
        else        src_q <= src;
    end

    for (genvar i = 0; i < N_SRC; i++) begin : g_pend
        // Pending bit update for source i.
        always_ff @(posedge clk) begin
            if (!rst_n)           pend[i] <= 1'b0;
            else if (lvl_mode[i]) pend[i] <= src[i];
            else                  pend[i] <= (src[i] && !src_q[i]) ||
                                             (pend[i] && !(clr_we && !keep[i]));
        end

        // R6: an edge source that sees a rising input is pending next cycle
        a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
            (!lvl_mode[i] && $rose(src[i])) |=> pend[i]);
        // R6: a level source follows its input one cycle later
        a_r6_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
            lvl_mode[i] |=> (pend[i] == $past(src[i])));
    end
endmodule

// File: rtl/irqc_arbiter.sv
// Combinational priority pick: lowest priority value wins, lower index on ties.
// Assumes priorities packed PRIO_W bits per source, source 0 at the bottom.
module irqc_arbiter #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 5,
    parameter int IDX_W  = 5
) (
    input  logic [N_SRC-1:0]        req,
    input  logic [N_SRC*PRIO_W-1:0] prio_flat,
    output logic                    found,
    output logic [IDX_W-1:0]        win
);
    // Linear scan; strict less-than keeps the lower index on a tie.
    always_comb begin
        logic [PRIO_W-1:0] best;
        found = 1'b0;
        win   = '0;
        best  = '0;
        for (int i = 0; i < N_SRC; i++) begin
            if (req[i] && (!found || prio_flat[i*PRIO_W +: PRIO_W] < best)) begin
                found = 1'b1;
                win   = IDX_W'(i);
                best  = prio_flat[i*PRIO_W +: PRIO_W];
            end
        end
    end
endmodule

// File: rtl/irqc_bank.sv
// One interrupt bank: configuration words, mask, pending capture, two arbiters
// and the held winner registers released by acknowledge writes.
// Assumes a single-cycle register port already decoded to this bank.
module irqc_bank
    import irqc_pkg::*;
#(
    parameter int N_SRC   = 32,
    parameter bit FAST_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [7:0]       ofs,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    input  logic [N_SRC-1:0] src,
    output logic             irq_req,
    output logic             fiq_req
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    src_cfg_t                cfg_q [N_SRC];
    logic [N_SRC-1:0]        mask_q, pend, lvl_mode, fast_sel, active, cand_n, cand_f;
    logic [N_SRC*PRIO_W-1:0] prio_flat;
    logic                    cfg_area, we_mask, we_pend, ack_n, ack_f;
    logic                    found_n, found_f, hold_n_q, hold_f_q;
    logic [IDX_W-1:0]        win_n, win_f, num_n_q, num_f_q;
    logic [4:0]              cfg_idx;

    assign cfg_idx  = ofs[6:2];
    assign cfg_area = ofs[7] && (ofs[1:0] == 2'b00) && (int'(cfg_idx) < N_SRC);
    assign we_mask  = wr_en && (ofs == OFS_MASK);
    assign we_pend  = wr_en && (ofs == OFS_PEND);
    assign ack_n    = wr_en && (ofs == OFS_CTRL) && wdata[0];
    assign ack_f    = wr_en && (ofs == OFS_CTRL) && wdata[1];

    for (genvar i = 0; i < N_SRC; i++) begin : g_cfg
        // Configuration word of source i.
        always_ff @(posedge clk) begin
            if (!rst_n)                                    cfg_q[i] <= '0;
            else if (wr_en && cfg_area && cfg_idx == 5'(i)) cfg_q[i] <= src_cfg_t'(wdata[CFG_W-1:0]);
        end
        assign lvl_mode[i]                   = cfg_q[i].lvl_mode;
        assign fast_sel[i]                   = FAST_EN && cfg_q[i].to_fast;
        assign prio_flat[i*PRIO_W +: PRIO_W] = cfg_q[i].prio;
    end

    // Mask register, all sources blocked after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '1;
        else if (we_mask) mask_q <= wdata[N_SRC-1:0];
    end

    irqc_capture #(.N_SRC(N_SRC)) u_capture (
        .clk      (clk),
        .rst_n    (rst_n),
        .src      (src),
        .lvl_mode (lvl_mode),
        .clr_we   (we_pend),
        .keep     (wdata[N_SRC-1:0]),
        .pend     (pend)
    );

    assign active = pend & ~mask_q;
    assign cand_n = active & ~fast_sel;
    assign cand_f = active & fast_sel;

    irqc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_n (
        .req (cand_n), .prio_flat (prio_flat), .found (found_n), .win (win_n)
    );
    irqc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_arb_f (
        .req (cand_f), .prio_flat (prio_flat), .found (found_f), .win (win_f)
    );

    // Normal winner hold: latch when free, release on acknowledge bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_n) begin
            hold_n_q <= 1'b0;
            num_n_q  <= '0;
        end else if (!hold_n_q && found_n) begin
            hold_n_q <= 1'b1;
            num_n_q  <= win_n;
        end
    end

    // Fast winner hold: latch when free, release on acknowledge bit 1.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_f) begin
            hold_f_q <= 1'b0;
            num_f_q  <= '0;
        end else if (!hold_f_q && found_f) begin
            hold_f_q <= 1'b1;
            num_f_q  <= win_f;
        end
    end

    assign irq_req = hold_n_q;
    assign fiq_req = hold_f_q;

    // Register read decode.
    always_comb begin
        rdata = '0;
        case (ofs)
            OFS_PEND:  rdata[N_SRC-1:0] = pend;
            OFS_MASK:  rdata[N_SRC-1:0] = mask_q;
            OFS_NUM_N: rdata[IDX_W-1:0] = num_n_q;
            OFS_NUM_F: rdata[IDX_W-1:0] = num_f_q;
            default:   if (cfg_area) rdata[CFG_W-1:0] = cfg_q[cfg_idx];
        endcase
    end

    // R10: a latched normal winner is frozen until acknowledged
    a_r10_normal_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n_q && !ack_n) |=> (hold_n_q && $stable(num_n_q)));
    // R10: a latched fast winner is frozen until acknowledged
    a_r10_fast_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_f_q && !ack_f) |=> (hold_f_q && $stable(num_f_q)));
    // R8: acknowledges release their request
    a_r8_ack_normal: assert property (@(posedge clk) disable iff (!rst_n)
        ack_n |=> !hold_n_q);
    a_r8_ack_fast: assert property (@(posedge clk) disable iff (!rst_n)
        ack_f |=> !hold_f_q);
    // R9: the arbiter only names an active candidate of its own type
    a_r9_win_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        found_n |-> cand_n[win_n]);
    // R11: a free request with a candidate latches at the next edge
    a_r11_rearbitrate: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_n_q && found_n && !ack_n) |=> (hold_n_q && num_n_q == $past(win_n)));
endmodule

// File: rtl/irqc_cascade.sv
// Two-bank interrupt controller: the second bank's held normal request is
// merged into first-bank source CASC_IDX. Registers on a one-cycle bus.
// Assumes all request inputs are synchronous to clk.
module irqc_cascade
    import irqc_pkg::*;
#(
    parameter int N_SRC    = 32,
    parameter int CASC_IDX = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_valid,
    input  logic             bus_write,
    input  logic [8:0]       bus_addr,
    input  logic [31:0]      bus_wdata,
    output logic             bus_ready,
    output logic [31:0]      bus_rdata,
    input  logic [N_SRC-1:0] prim_src,
    input  logic [N_SRC-1:0] sec_src,
    output logic             irq_n,
    output logic             fiq_n
);
    logic             sel_sec, we_prim, we_sec;
    logic [31:0]      rd_prim, rd_sec;
    logic             prim_irq, prim_fiq, sec_irq, sec_fiq;
    logic [N_SRC-1:0] prim_in;

    assign sel_sec = bus_addr[8];
    assign we_prim = bus_valid && bus_write && !sel_sec;
    assign we_sec  = bus_valid && bus_write && sel_sec;

    // Merge the chained bank's request into its cascade source.
    always_comb begin
        prim_in           = prim_src;
        prim_in[CASC_IDX] = prim_src[CASC_IDX] | sec_irq;
    end

    irqc_bank #(.N_SRC(N_SRC), .FAST_EN(1'b1)) u_prim (
        .clk (clk), .rst_n (rst_n), .wr_en (we_prim), .ofs (bus_addr[7:0]),
        .wdata (bus_wdata), .rdata (rd_prim), .src (prim_in),
        .irq_req (prim_irq), .fiq_req (prim_fiq)
    );

    irqc_bank #(.N_SRC(N_SRC), .FAST_EN(1'b0)) u_sec (
        .clk (clk), .rst_n (rst_n), .wr_en (we_sec), .ofs (bus_addr[7:0]),
        .wdata (bus_wdata), .rdata (rd_sec), .src (sec_src),
        .irq_req (sec_irq), .fiq_req (sec_fiq)
    );

    // Bus completion and registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_valid;
            if (bus_valid && !bus_write) bus_rdata <= sel_sec ? rd_sec : rd_prim;
        end
    end

    assign irq_n = !prim_irq;
    assign fiq_n = !prim_fiq;

    // R3: the chained bank never raises a fast request
    a_r3_sec_no_fast: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_fiq);
    // R12: while the chained bank holds a request, first-bank output stays busy
    a_r12_chain_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_irq && !prim_irq && !we_prim) |=> ##1 (prim_irq || !$past(sec_irq)));
endmodule

// File: tb/irqc_cascade_tb.sv
module irqc_cascade_tb;
    localparam int N = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0, bus_write = 1'b0;
    logic [8:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ready;
    logic [31:0] bus_rdata;
    logic [N-1:0] prim_src = '0, sec_src = '0;
    logic        irq_n, fiq_n;

    int n_chk = 0, n_bad = 0;
    int prio_m [N];
    logic [31:0] rd;

    always #2 clk = ~clk;

    irqc_cascade #(.N_SRC(N), .CASC_IDX(0)) u_dut (
        .clk (clk), .rst_n (rst_n), .bus_valid (bus_valid), .bus_write (bus_write),
        .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_ready (bus_ready),
        .bus_rdata (bus_rdata), .prim_src (prim_src), .sec_src (sec_src),
        .irq_n (irq_n), .fiq_n (fiq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [8:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [8:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic wait_cyc(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    function automatic logic [31:0] cfg(input int pr, input bit lvl, input bit fst);
        return {25'b0, pr[4:0], lvl, fst};
    endfunction

    // Model of R9: lowest priority value, lower index on ties; -1 if none.
    function automatic int winner(input logic [31:0] act);
        int w = -1;
        for (int i = 0; i < N; i++)
            if (act[i] && (w < 0 || prio_m[i] < prio_m[w])) w = i;
        return w;
    endfunction

    task automatic run_norm(input logic [31:0] pat, input logic [31:0] msk);
        int w;
        bus_wr(9'h004, msk);
        prim_src = pat;
        wait_cyc(3);
        w = winner(pat & ~msk);
        bus_rd(9'h008, rd);
        check("R9 winner number", rd, (w < 0) ? 32'd0 : 32'(w));
        check("R4 request line", {31'b0, irq_n}, (w < 0) ? 32'd1 : 32'd0);
        prim_src = '0;
        wait_cyc(2);
        bus_wr(9'h010, 32'h1);
        wait_cyc(1);
        check("R8 released", {31'b0, irq_n}, 32'd1);
    endtask

    initial begin : watchdog
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(1);

        // Reset state (R4, R5, R7, R8)
        check("R8 irq_n reset", {31'b0, irq_n}, 32'd1);
        check("R8 fiq_n reset", {31'b0, fiq_n}, 32'd1);
        bus_rd(9'h004, rd); check("R4 prim mask reset", rd, 32'hFFFF_FFFF);
        check("R13 ready after valid", {31'b0, bus_ready}, 32'd1);
        wait_cyc(1);
        check("R13 ready one cycle", {31'b0, bus_ready}, 32'd0);
        bus_rd(9'h104, rd); check("R4 sec mask reset", rd, 32'hFFFF_FFFF);
        bus_rd(9'h000, rd); check("R5 pending reset", rd, 32'd0);
        bus_rd(9'h008, rd); check("R7 number reset", rd, 32'd0);
        bus_rd(9'h0A0, rd); check("R2 cfg reset", rd, 32'd0);

        // R2/R1: configuration words of both banks, upper bits dropped
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < N; i++)
                bus_wr({b[0], 8'h80 + 8'(4 * i)}, 32'hFFFF_FF80 | ((i * 37 + 11 + b * 5) & 32'h7F));
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < N; i++) begin
                bus_rd({b[0], 8'h80 + 8'(4 * i)}, rd);
                check("R2 cfg readback", rd, (i * 37 + 11 + b * 5) & 32'h7F);
            end

        // R9/R4/R7: level sources, priorities with ties
        for (int i = 0; i < N; i++) begin
            prio_m[i] = (i * 13 + 5) % 9;
            bus_wr(9'h080 + 9'(4 * i), cfg(prio_m[i], 1'b1, 1'b0));
        end
        for (int i = 0; i < N; i++) run_norm(32'h1 << i, 32'h0);
        for (int n = 0; n < 24; n++) begin
            logic [31:0] p, m;
            p = (32'(n) * 32'h2545_F491) ^ (32'h1 << (n % 32));
            m = (n < 6) ? 32'h0 : ((32'(n) * 32'h9E37_79B9) >> 3);
            if (n == 23) m = 32'hFFFF_FFFF;
            run_norm(p, m);
        end

        // R3/R8: fast routing in the first bank
        bus_wr(9'h094, cfg(3, 1'b1, 1'b1));
        bus_wr(9'h0A4, cfg(1, 1'b1, 1'b0));
        bus_wr(9'h004, ~((32'h1 << 5) | (32'h1 << 9)));
        prim_src = (32'h1 << 5) | (32'h1 << 9);
        wait_cyc(3);
        check("R3 fast line", {31'b0, fiq_n}, 32'd0);
        bus_rd(9'h00C, rd); check("R3 fast number", rd, 32'd5);
        bus_rd(9'h008, rd); check("R3 normal number", rd, 32'd9);
        prim_src = '0;
        wait_cyc(2);
        bus_wr(9'h010, 32'h2);
        check("R8 fast only released", {30'b0, irq_n, fiq_n}, 32'b01 ^ 32'b00 | 32'b01);
        bus_wr(9'h010, 32'h3);
        check("R8 both released", {30'b0, irq_n, fiq_n}, 32'b11);

        // R10/R11: freeze then re-arbitrate the cycle after release
        bus_wr(9'h0D0, cfg(10, 1'b1, 1'b0));
        bus_wr(9'h0D4, cfg(2, 1'b1, 1'b0));
        bus_wr(9'h004, ~((32'h1 << 20) | (32'h1 << 21)));
        prim_src = 32'h1 << 20;
        wait_cyc(3);
        bus_rd(9'h008, rd); check("R10 first winner", rd, 32'd20);
        prim_src = (32'h1 << 20) | (32'h1 << 21);
        wait_cyc(3);
        bus_rd(9'h008, rd); check("R10 frozen number", rd, 32'd20);
        check("R10 line held", {31'b0, irq_n}, 32'd0);
        prim_src = 32'h1 << 21;
        wait_cyc(1);
        bus_wr(9'h010, 32'h1);
        check("R8 release edge", {31'b0, irq_n}, 32'd1);
        wait_cyc(1);
        check("R11 reassert next cycle", {31'b0, irq_n}, 32'd0);
        bus_rd(9'h008, rd); check("R11 new winner", rd, 32'd21);
        prim_src = '0;
        wait_cyc(2);
        bus_wr(9'h010, 32'h1);

        // R6/R5: edge capture, clear, level tracking
        bus_wr(9'h0B0, cfg(4, 1'b0, 1'b0));
        bus_wr(9'h0B4, cfg(6, 1'b1, 1'b0));
        bus_wr(9'h004, ~((32'h1 << 12) | (32'h1 << 13)));
        @(negedge clk); prim_src = 32'h1 << 12;
        @(negedge clk); prim_src = '0;
        wait_cyc(2);
        bus_rd(9'h000, rd); check("R6 edge stays pending", rd, 32'h1 << 12);
        bus_rd(9'h008, rd); check("R6 edge winner", rd, 32'd12);
        bus_wr(9'h000, ~(32'h1 << 12));
        bus_rd(9'h000, rd); check("R5 edge cleared", rd, 32'd0);
        bus_wr(9'h010, 32'h1);
        wait_cyc(2);
        check("R5 no relatch after clear", {31'b0, irq_n}, 32'd1);
        prim_src = 32'h1 << 13;
        wait_cyc(2);
        bus_rd(9'h000, rd); check("R6 level pending", rd, 32'h1 << 13);
        bus_wr(9'h000, 32'h0);
        bus_rd(9'h000, rd); check("R5 level unaffected", rd, 32'h1 << 13);
        prim_src = '0;
        wait_cyc(2);
        bus_rd(9'h000, rd); check("R6 level follows low", rd, 32'd0);
        bus_wr(9'h010, 32'h1);

        // R12/R3/R1: cascade from the second bank
        bus_wr(9'h080, cfg(0, 1'b1, 1'b0));
        bus_wr(9'h004, 32'hFFFF_FFFE);
        bus_wr(9'h190, cfg(2, 1'b1, 1'b1));
        bus_wr(9'h104, ~(32'h1 << 4));
        sec_src = 32'h1 << 4;
        wait_cyc(4);
        check("R3 sec fast ignored", {30'b0, irq_n, fiq_n}, 32'b01);
        bus_rd(9'h008, rd); check("R12 cascade source", rd, 32'd0);
        bus_rd(9'h108, rd); check("R1 global number", rd + 32, 32'd36);
        bus_rd(9'h10C, rd); check("R3 sec fast number", rd, 32'd0);
        sec_src = '0;
        wait_cyc(1);
        bus_wr(9'h010, 32'h1);
        wait_cyc(3);
        check("R12 first-bank ack alone", {31'b0, irq_n}, 32'd0);
        bus_wr(9'h110, 32'h1);
        wait_cyc(2);
        bus_wr(9'h010, 32'h1);
        wait_cyc(3);
        check("R12 chain cleared", {31'b0, irq_n}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule